// File: doc/BRIEF.md
# Snooping Cache Bus-Side Controller

This block is the bus-facing half of a small, fully associative, write-back cache that keeps coherence by watching a split-transaction bus. Each accepted packet carries a command, a requester ID, a shared flag, a real word address, a single data word, a compare value and a full data block. The block matches the packet against its lines by real block tag and updates the per-line owner, shared and two valid bits. It drives the wired shared and owner response lines. Replies it must source are pushed into an outbound high-priority queue.

A single snooper watches the block address of this cache's own outstanding request. While the request is pending, the snooper gathers a sharing hint from foreign reads of that block. It also marks the pending reply stale when a foreign device writes that block first. The processor side picks the victim line and holds its virtual address on `proc_vaddr_i`. It also reads the line array through a virtual-tag lookup port. A packet is own when `pkt_id_i` equals `my_id_i`.

Top module: `snoop_cache_ctl`

## Requirements
- R1: After reset no line is valid (`proc_hit_o`=0), the outbound queue is empty, `pend_o`, `victim_lock_o`, `bus_shared_o` and `bus_owner_o` are 0 and `pkt_ready_o` is 1. Command codes are: read-block request 0 / reply 1, write-single 2 / 3, conditional write-single 4 / 5, write-block 6 / 7, IO read 8 / 9, IO write 10 / 11.
- R2: An own read-block request arms the snooper with the packet's block address. It clears both valid bits of line `victim_i` and sets `pend_o` and `victim_lock_o`.
- R3: A foreign read-block request that hits a valid line sets that line's shared bit, and one that hits the armed snooper sets the sharing accumulator. In the cycle after acceptance, `bus_shared_o` is 1 on either hit and `bus_owner_o` is 1 when the hit line is owned.
- R4: When that hit line is owned, a reply with code 1, shared=1, the packet address and the line's whole block is enqueued.
- R5: An own read-block reply disarms the snooper and clears `pend_o` and `victim_lock_o`. Without a real hit it fills the victim line: real tag and data from the packet, virtual tag from `proc_vaddr_i`, owner 0, shared = accumulator OR packet shared, real valid 1, virtual valid = NOT stale. With a real hit only that line's virtual tag is replaced.
- R6: A write-single reply (3 or 5) that hits a line sets its shared bit to packet shared OR (own AND accumulator). It sets its owner bit to 1 exactly when the reply is own.
- R7: The word inside a block is selected by the low log2(WORDS) address bits. A write-single reply writes `pkt_wdata_i` there; code 5 writes only when the current word equals `pkt_old_i`.
- R8: A foreign write-single reply (3 or 5) or a foreign write-block request (6) that hits the armed snooper sets its stale flag. A later own fill then leaves the line virtually invalid.
- R9: A foreign write-block request that hits a line replaces the line's block with the packet block and clears its owner bit.
- R10: An IO read request (8) hitting a line enqueues code 9 with the addressed word in lane 0 (bits DW-1:0). An IO write request (10) hitting a line writes `pkt_wdata_i` to the word and enqueues code 11 carrying it in lane 0.
- R11: While the outbound queue is full, `pkt_ready_o` is 0 and an offered packet is held with no state change until a slot frees.
- R12: A foreign write-single request (2 or 4) sets `bus_shared_o` on a line or snooper hit and never sets `bus_owner_o`.
- R13: `pend_o` is set by any own request (even code) and cleared by any own reply (odd code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_id_i | input | IDW | This cache's device ID |
| victim_i | input | log2(LINES) | Victim line chosen by the processor side |
| pkt_valid_i | input | 1 | Inbound packet valid |
| pkt_ready_o | output | 1 | Inbound packet accepted when high with valid |
| pkt_cmd_i | input | 4 | Command code |
| pkt_id_i | input | IDW | Requester ID |
| pkt_shared_i | input | 1 | Packet shared flag |
| pkt_addr_i | input | AW | Real word address |
| pkt_wdata_i | input | DW | Single word for write-single and IO write |
| pkt_old_i | input | DW | Compare value for conditional write-single |
| pkt_data_i | input | WORDS*DW | Data block, word k in bits k*DW +: DW |
| bus_shared_o | output | 1 | Shared response line |
| bus_owner_o | output | 1 | Owner response line |
| out_valid_o | output | 1 | Outbound reply available |
| out_ready_i | input | 1 | Outbound reply taken |
| out_cmd_o | output | 4 | Reply command code |
| out_shared_o | output | 1 | Reply shared flag |
| out_addr_o | output | AW | Reply address |
| out_data_o | output | WORDS*DW | Reply block |
| proc_vaddr_i | input | AW | Processor virtual word address |
| proc_hit_o | output | 1 | Virtual lookup hit |
| proc_owner_o | output | 1 | Owner bit of hit line |
| proc_shared_o | output | 1 | Shared bit of hit line |
| proc_rdata_o | output | DW | Addressed word of hit line |
| pend_o | output | 1 | Own request outstanding |
| victim_lock_o | output | 1 | Victim line locked by own read |

## Verification
The hardest situation to reach is a stale fill. This cache must have its own read armed, then see a foreign write to the same block before its own reply arrives. Only then does the new line come up real-valid but virtually invalid. The stimulus interleaves an own read-block request, a foreign write-block or write-single reply to that block and the own reply. It then shows the result at the ports: the virtual lookup misses while a foreign read still gets a shared response. The full-queue hold is reached by leaving `out_ready_i` low through enough owned or IO hits to fill the queue, then offering one more packet and releasing a single slot.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;
  typedef enum logic [3:0] {
    CMD_RD_REQ  = 4'd0,
    CMD_RD_RPL  = 4'd1,
    CMD_WS_REQ  = 4'd2,
    CMD_WS_RPL  = 4'd3,
    CMD_CWS_REQ = 4'd4,
    CMD_CWS_RPL = 4'd5,
    CMD_WB_REQ  = 4'd6,
    CMD_WB_RPL  = 4'd7,
    CMD_IOR_REQ = 4'd8,
    CMD_IOR_RPL = 4'd9,
    CMD_IOW_REQ = 4'd10,
    CMD_IOW_RPL = 4'd11
  } bus_cmd_e;
endpackage

// File: rtl/scc_prio_enc.sv
module scc_prio_enc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign hit_o = |req_i;
endmodule

// File: rtl/scc_snooper.sv
module scc_snooper #(
  parameter int TW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          disarm_i,
  input  logic [TW-1:0] tag_i,
  input  logic          share_i,
  input  logic          stale_i,
  output logic          hit_o,
  output logic          en_o,
  output logic          shared_o,
  output logic          stale_o
);
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      shared_o <= 1'b0;
      stale_o  <= 1'b0;
      tag_q    <= '0;
    end else if (arm_i) begin
      en_o     <= 1'b1;
      shared_o <= 1'b0;
      stale_o  <= 1'b0;
      tag_q    <= tag_i;
    end else begin
      if (disarm_i) en_o <= 1'b0;
      if (share_i)  shared_o <= 1'b1;
      if (stale_i)  stale_o <= 1'b1;
    end
  end

  assign hit_o = en_o && (tag_q == tag_i);

  assert_arm_fresh_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> en_o && !shared_o && !stale_o);
  assert_stale_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_o && !arm_i |=> stale_o);
  assert_stale_needs_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_i |-> en_o);
endmodule

// File: rtl/scc_reply_fifo.sv
module scc_reply_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_pop;

  assign do_pop  = pop_i && valid_o;
  assign valid_o = (cnt != '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign data_o  = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_i) begin
        mem[wptr] <= data_i;
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
      if (do_pop) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(do_pop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_count_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/snoop_cache_ctl.sv
module snoop_cache_ctl
  import snoop_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int WORDS  = 8,
  parameter int DW     = 32,
  parameter int AW     = 16,
  parameter int IDW    = 4,
  parameter int QDEPTH = 4,
  localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BW    = WORDS * DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [IDW-1:0] my_id_i,
  input  logic [IW-1:0]  victim_i,
  input  logic           pkt_valid_i,
  output logic           pkt_ready_o,
  input  logic [3:0]     pkt_cmd_i,
  input  logic [IDW-1:0] pkt_id_i,
  input  logic           pkt_shared_i,
  input  logic [AW-1:0]  pkt_addr_i,
  input  logic [DW-1:0]  pkt_wdata_i,
  input  logic [DW-1:0]  pkt_old_i,
  input  logic [BW-1:0]  pkt_data_i,
  output logic           bus_shared_o,
  output logic           bus_owner_o,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [3:0]     out_cmd_o,
  output logic           out_shared_o,
  output logic [AW-1:0]  out_addr_o,
  output logic [BW-1:0]  out_data_o,
  input  logic [AW-1:0]  proc_vaddr_i,
  output logic           proc_hit_o,
  output logic           proc_owner_o,
  output logic           proc_shared_o,
  output logic [DW-1:0]  proc_rdata_o,
  output logic           pend_o,
  output logic           victim_lock_o
);
  localparam int OW = $clog2(WORDS);
  localparam int TW = AW - OW;
  localparam int RW = 4 + 1 + AW + BW;

  // line array
  logic [LINES-1:0] l_own, l_shr, l_rv, l_vv;
  logic [TW-1:0]    l_rtag [LINES];
  logic [TW-1:0]    l_vtag [LINES];
  logic [BW-1:0]    l_data [LINES];

  logic [TW-1:0] p_tag, v_tag;
  logic [OW-1:0] p_off, v_off;
  assign p_tag = pkt_addr_i[AW-1:OW];
  assign p_off = pkt_addr_i[OW-1:0];
  assign v_tag = proc_vaddr_i[AW-1:OW];
  assign v_off = proc_vaddr_i[OW-1:0];

  logic [LINES-1:0] rmatch, vmatch;
  for (genvar g = 0; g < LINES; g++) begin : g_match
    assign rmatch[g] = l_rv[g] && (l_rtag[g] == p_tag);
    assign vmatch[g] = l_vv[g] && (l_vtag[g] == v_tag);
  end

  logic          r_hit, v_hit;
  logic [IW-1:0] r_idx, v_idx;
  scc_prio_enc #(.N(LINES), .IW(IW)) u_renc (.req_i(rmatch), .hit_o(r_hit), .idx_o(r_idx));
  scc_prio_enc #(.N(LINES), .IW(IW)) u_venc (.req_i(vmatch), .hit_o(v_hit), .idx_o(v_idx));

  logic [BW-1:0] hit_blk, v_blk;
  logic [DW-1:0] hit_word;
  assign hit_blk  = l_data[r_idx];
  assign hit_word = hit_blk[int'(p_off)*DW +: DW];
  assign v_blk    = l_data[v_idx];

  assign proc_hit_o    = v_hit;
  assign proc_owner_o  = v_hit && l_own[v_idx];
  assign proc_shared_o = v_hit && l_shr[v_idx];
  assign proc_rdata_o  = v_hit ? v_blk[int'(v_off)*DW +: DW] : '0;

  // packet decode
  logic     acc, own, q_full;
  bus_cmd_e cmd;
  assign pkt_ready_o = !q_full;
  assign acc = pkt_valid_i && pkt_ready_o;
  assign own = (pkt_id_i == my_id_i);
  assign cmd = bus_cmd_e'(pkt_cmd_i);

  logic sn_hit, sn_en, sn_shared, sn_stale;
  logic arm, disarm, set_share, set_stale;
  logic nxt_bs, nxt_bo, push, push_shr;
  logic [3:0]    push_cmd;
  logic [BW-1:0] push_data;

  always_comb begin
    arm = 1'b0; disarm = 1'b0; set_share = 1'b0; set_stale = 1'b0;
    nxt_bs = 1'b0; nxt_bo = 1'b0;
    push = 1'b0; push_shr = 1'b0; push_cmd = '0; push_data = '0;
    if (acc) begin
      unique case (cmd)
        CMD_RD_REQ: begin
          if (own) arm = 1'b1;
          else begin
            set_share = sn_hit;
            nxt_bs    = r_hit || sn_hit;
            nxt_bo    = r_hit && l_own[r_idx];
            if (r_hit && l_own[r_idx]) begin
              push = 1'b1; push_cmd = CMD_RD_RPL; push_shr = 1'b1; push_data = hit_blk;
            end
          end
        end
        CMD_WS_REQ, CMD_CWS_REQ: begin
          if (own) arm = 1'b1;
          else nxt_bs = r_hit || sn_hit;
        end
        CMD_WS_RPL, CMD_CWS_RPL: begin
          if (own) disarm = 1'b1;
          else set_stale = sn_hit;
        end
        CMD_WB_REQ: begin
          if (own) arm = 1'b1;
          else set_stale = sn_hit;
        end
        CMD_RD_RPL, CMD_WB_RPL: disarm = own;
        CMD_IOR_REQ: if (r_hit) begin
          push = 1'b1; push_cmd = CMD_IOR_RPL; push_data = BW'(hit_word);
        end
        CMD_IOW_REQ: if (r_hit) begin
          push = 1'b1; push_cmd = CMD_IOW_RPL; push_data = BW'(pkt_wdata_i);
        end
        default: ;
      endcase
    end
  end

  scc_snooper #(.TW(TW)) u_snoop (
    .clk_i, .rst_ni,
    .arm_i(arm), .disarm_i(disarm), .tag_i(p_tag),
    .share_i(set_share), .stale_i(set_stale),
    .hit_o(sn_hit), .en_o(sn_en), .shared_o(sn_shared), .stale_o(sn_stale)
  );

  logic [RW-1:0] q_out;
  scc_reply_fifo #(.W(RW), .DEPTH(QDEPTH)) u_q (
    .clk_i, .rst_ni,
    .push_i(push), .data_i({push_cmd, push_shr, pkt_addr_i, push_data}),
    .full_o(q_full), .pop_i(out_ready_i), .valid_o(out_valid_o), .data_o(q_out)
  );
  assign {out_cmd_o, out_shared_o, out_addr_o, out_data_o} = q_out;

  logic cond_ok;
  assign cond_ok = (cmd != CMD_CWS_RPL) || (hit_word == pkt_old_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_own <= '0; l_shr <= '0; l_rv <= '0; l_vv <= '0;
      for (int i = 0; i < LINES; i++) begin
        l_rtag[i] <= '0; l_vtag[i] <= '0; l_data[i] <= '0;
      end
    end else if (acc) begin
      unique case (cmd)
        CMD_RD_REQ: begin
          if (own) begin
            l_rv[victim_i] <= 1'b0;
            l_vv[victim_i] <= 1'b0;
          end else if (r_hit) l_shr[r_idx] <= 1'b1;
        end
        CMD_RD_RPL: if (own) begin
          if (r_hit) l_vtag[r_idx] <= v_tag;
          else begin
            l_own[victim_i]  <= 1'b0;
            l_shr[victim_i]  <= sn_shared || pkt_shared_i;
            l_rv[victim_i]   <= 1'b1;
            l_vv[victim_i]   <= !sn_stale;
            l_rtag[victim_i] <= p_tag;
            l_vtag[victim_i] <= v_tag;
            l_data[victim_i] <= pkt_data_i;
          end
        end
        CMD_WS_RPL, CMD_CWS_RPL: if (r_hit) begin
          l_shr[r_idx] <= pkt_shared_i || (own && sn_shared);
          l_own[r_idx] <= own;
          if (cond_ok) l_data[r_idx][int'(p_off)*DW +: DW] <= pkt_wdata_i;
        end
        CMD_WB_REQ: if (!own && r_hit) begin
          l_data[r_idx] <= pkt_data_i;
          l_own[r_idx]  <= 1'b0;
        end
        CMD_IOW_REQ: if (r_hit) l_data[r_idx][int'(p_off)*DW +: DW] <= pkt_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0; victim_lock_o <= 1'b0;
      bus_shared_o <= 1'b0; bus_owner_o <= 1'b0;
    end else begin
      bus_shared_o <= nxt_bs;
      bus_owner_o  <= nxt_bo;
      if (acc && own && cmd <= CMD_IOW_RPL) pend_o <= !pkt_cmd_i[0];
      if (acc && own && cmd == CMD_RD_REQ) victim_lock_o <= 1'b1;
      if (acc && own && cmd == CMD_RD_RPL) victim_lock_o <= 1'b0;
    end
  end

  assert_owner_implies_shared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_owner_o |-> bus_shared_o);
  assert_owned_hit_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd == CMD_RD_REQ && !own && r_hit && l_own[r_idx] |=> out_valid_o);
  assert_victim_cleared_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd == CMD_RD_REQ && own |=> !l_rv[$past(victim_i)] && !l_vv[$past(victim_i)] && sn_en);
  assert_fill_real_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd == CMD_RD_RPL && own && !r_hit |=> l_rv[$past(victim_i)] && !sn_en);
  assert_held_no_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && !pkt_ready_o |=> $stable(l_own) && $stable(l_rv) && $stable(l_vv));
  assert_ws_req_no_owner_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !own && (cmd == CMD_WS_REQ || cmd == CMD_CWS_REQ) |=> !bus_owner_o);
  assert_reply_clears_pend_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && own && pkt_cmd_i[0] && cmd <= CMD_IOW_RPL |=> !pend_o);
endmodule

// File: tb/snoop_cache_ctl_tb.sv
module snoop_cache_ctl_tb_top;
  import snoop_cache_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8, DW = 32, AW = 16, IDW = 4, BW = WORDS * DW;
  localparam logic [IDW-1:0] MY = 4'd1, FOR = 4'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [IDW-1:0] pkt_id;
  logic [1:0]     victim;
  logic           pkt_valid, pkt_ready, pkt_shared, bus_shared, bus_owner;
  logic [3:0]     pkt_cmd, out_cmd;
  logic [AW-1:0]  pkt_addr, out_addr, proc_vaddr;
  logic [DW-1:0]  pkt_wdata, pkt_old, proc_rdata;
  logic [BW-1:0]  pkt_data, out_data;
  logic           out_valid, out_ready, out_shared;
  logic           proc_hit, proc_owner, proc_shared, pend, vlock;

  snoop_cache_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .my_id_i(MY), .victim_i(victim),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_cmd_i(pkt_cmd),
    .pkt_id_i(pkt_id), .pkt_shared_i(pkt_shared), .pkt_addr_i(pkt_addr),
    .pkt_wdata_i(pkt_wdata), .pkt_old_i(pkt_old), .pkt_data_i(pkt_data),
    .bus_shared_o(bus_shared), .bus_owner_o(bus_owner),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_cmd_o(out_cmd),
    .out_shared_o(out_shared), .out_addr_o(out_addr), .out_data_o(out_data),
    .proc_vaddr_i(proc_vaddr), .proc_hit_o(proc_hit), .proc_owner_o(proc_owner),
    .proc_shared_o(proc_shared), .proc_rdata_o(proc_rdata),
    .pend_o(pend), .victim_lock_o(vlock)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bw(input logic [AW-1:0] a, input int k);
    return (DW'(a) << 16) | DW'(k);
  endfunction

  function automatic logic [BW-1:0] blk(input logic [AW-1:0] a);
    logic [BW-1:0] b;
    for (int k = 0; k < WORDS; k++) b[k*DW +: DW] = bw(a, k);
    return b;
  endfunction

  task automatic send(input logic [3:0] c, input bit is_own, input logic sh,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] old, input logic [BW-1:0] d);
    logic r;
    pkt_cmd = c; pkt_id = is_own ? MY : FOR; pkt_shared = sh;
    pkt_addr = a; pkt_wdata = wd; pkt_old = old; pkt_data = d; pkt_valid = 1'b1;
    do begin
      r = pkt_ready;
      @(negedge clk);
    end while (!r);
    pkt_valid = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [3:0] c, input logic sh,
                           input logic [AW-1:0] a, input int k, input logic [DW-1:0] w);
    check(req, out_valid, 1);
    check(req, out_cmd, c);
    check(req, out_shared, sh);
    check(req, out_addr, a);
    check(req, out_data[k*DW +: DW], w);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  cmd;
    logic        own;
    logic        sh;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [5:0]  exp; // bus_shared, bus_owner, pend, hit, owner, shared
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b1, 1'b0, 16'h0040, 32'h0,    6'b001000},
    '{4'd1, 1'b1, 1'b0, 16'h0040, 32'h0,    6'b000100},
    '{4'd0, 1'b0, 1'b0, 16'h0040, 32'h0,    6'b100101},
    '{4'd0, 1'b0, 1'b0, 16'h0080, 32'h0,    6'b000101},
    '{4'd2, 1'b1, 1'b0, 16'h0043, 32'h0,    6'b001101},
    '{4'd2, 1'b0, 1'b0, 16'h0041, 32'h0,    6'b101101},
    '{4'd3, 1'b1, 1'b0, 16'h0043, 32'hAAAA, 6'b000110},
    '{4'd0, 1'b0, 1'b0, 16'h0040, 32'h0,    6'b110111}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pkt_valid = 0; pkt_cmd = 0; pkt_id = 0; pkt_shared = 0; pkt_addr = 0;
    pkt_wdata = 0; pkt_old = 0; pkt_data = 0; out_ready = 0; victim = 0;
    proc_vaddr = 16'h1043;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", pkt_ready, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 pend", pend, 0);
    check("R1 lock", vlock, 0);
    check("R1 bus", {bus_shared, bus_owner}, 0);
    check("R1 hit", proc_hit, 0);

    // table walk: fill, sharing, ownership (R3 R5 R6 R12 R13)
    for (int i = 0; i < 8; i++) begin
      send(VECS[i].cmd, VECS[i].own, VECS[i].sh, VECS[i].addr, VECS[i].wdata, 0,
           blk(VECS[i].addr));
      check($sformatf("R3_R12 bus step %0d", i), {bus_shared, bus_owner}, VECS[i].exp[5:4]);
      check($sformatf("R13 pend step %0d", i), pend, VECS[i].exp[3]);
      check($sformatf("R5_R6 line step %0d", i), {proc_hit, proc_owner, proc_shared},
            VECS[i].exp[2:0]);
    end
    check("R7 word3", proc_rdata, 32'hAAAA);
    // R4 owned-hit reply
    pop_check("R4 rd reply", 4'd1, 1'b1, 16'h0040, 3, 32'hAAAA);
    check("R4 word0", out_data[DW-1:0], 32'h0);
    check("R4 drained", out_valid, 0);

    // R7 conditional write
    proc_vaddr = 16'h1042;
    send(CMD_CWS_REQ, 1, 0, 16'h0042, 0, 0, '0);
    check("R13 cws pend", pend, 1);
    send(CMD_CWS_RPL, 1, 1, 16'h0042, 32'h5555, 32'h0, '0);
    check("R7 cws mismatch", proc_rdata, bw(16'h0040, 2));
    check("R6 own sh", {proc_owner, proc_shared}, 2'b11);
    send(CMD_CWS_RPL, 1, 0, 16'h0042, 32'h5555, bw(16'h0040, 2), '0);
    check("R7 cws match", proc_rdata, 32'h5555);
    check("R6 acc0", {proc_owner, proc_shared}, 2'b10);
    // R6 foreign reply drops ownership
    proc_vaddr = 16'h1041;
    send(CMD_WS_RPL, 0, 1, 16'h0041, 32'h1111, 0, '0);
    check("R6 foreign", {proc_owner, proc_shared}, 2'b01);
    check("R7 word1", proc_rdata, 32'h1111);

    // R10 IO
    send(CMD_IOR_REQ, 0, 0, 16'h0041, 0, 0, '0);
    send(CMD_IOW_REQ, 0, 0, 16'h0045, 32'h7777, 0, '0);
    proc_vaddr = 16'h1045;
    #1;
    check("R10 iow word", proc_rdata, 32'h7777);
    pop_check("R10 ior reply", 4'd9, 1'b0, 16'h0041, 0, 32'h1111);
    pop_check("R10 iow reply", 4'd11, 1'b0, 16'h0045, 0, 32'h7777);

    // R9 write-block
    proc_vaddr = 16'h1040;
    send(CMD_WS_RPL, 1, 0, 16'h0040, 32'hBEEF, 0, '0);
    check("R9 owned before", proc_owner, 1);
    send(CMD_WB_REQ, 0, 0, 16'h0040, 0, 0, blk(16'h0900));
    check("R9 owner cleared", proc_owner, 0);
    check("R9 data", proc_rdata, bw(16'h0900, 0));

    // R13 write-block own
    send(CMD_WB_REQ, 1, 0, 16'h0040, 0, 0, '0);
    check("R13 wb pend", pend, 1);
    send(CMD_WB_RPL, 1, 0, 16'h0040, 0, 0, '0);
    check("R13 wb clear", pend, 0);

    // R11 full queue holds packet
    for (int i = 0; i < 4; i++) send(CMD_IOR_REQ, 0, 0, 16'h0040, 0, 0, '0);
    check("R11 ready low", pkt_ready, 0);
    proc_vaddr = 16'h1046;
    pkt_cmd = CMD_IOW_REQ; pkt_id = FOR; pkt_addr = 16'h0046; pkt_wdata = 32'h9999;
    pkt_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 held", proc_rdata, bw(16'h0900, 6));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    pkt_valid = 1'b0;
    check("R11 accepted", proc_rdata, 32'h9999);
    out_ready = 1'b1;
    repeat (6) @(negedge clk);
    out_ready = 1'b0;
    check("R11 drained", out_valid, 0);

    // R2 victim invalidation
    victim = 0;
    send(CMD_RD_REQ, 1, 0, 16'h0100, 0, 0, '0);
    check("R2 victim miss", proc_hit, 0);
    check("R2 pend lock", {pend, vlock}, 2'b11);
    send(CMD_RD_REQ, 0, 0, 16'h0040, 0, 0, '0);
    check("R2 real invalid", bus_shared, 0);
    proc_vaddr = 16'h5100;
    send(CMD_RD_RPL, 1, 0, 16'h0100, 0, 0, blk(16'h0100));
    check("R5 fill hit", proc_hit, 1);
    check("R5 unlock", {pend, vlock}, 2'b00);
    check("R5 fill data", proc_rdata, bw(16'h0100, 0));

    // R3 R5 accumulator from snooper-only hit
    victim = 2; proc_vaddr = 16'h30C0;
    send(CMD_RD_REQ, 1, 0, 16'h00C0, 0, 0, '0);
    send(CMD_RD_REQ, 0, 0, 16'h00C0, 0, 0, '0);
    check("R3 snoop shared", {bus_shared, bus_owner}, 2'b10);
    send(CMD_RD_RPL, 1, 0, 16'h00C0, 0, 0, blk(16'h00C0));
    check("R5 acc fill", {proc_hit, proc_owner, proc_shared}, 3'b101);

    // R8 stale through foreign write-block
    victim = 1; proc_vaddr = 16'h2080;
    send(CMD_RD_REQ, 1, 0, 16'h0080, 0, 0, '0);
    send(CMD_WB_REQ, 0, 0, 16'h0083, 0, 0, blk(16'h0A00));
    send(CMD_RD_RPL, 1, 0, 16'h0080, 0, 0, blk(16'h0080));
    check("R8 stale wb", proc_hit, 0);
    send(CMD_RD_REQ, 0, 0, 16'h0080, 0, 0, '0);
    check("R5 real valid", bus_shared, 1);
    // R8 stale through foreign write-single reply
    victim = 3; proc_vaddr = 16'h6140;
    send(CMD_RD_REQ, 1, 0, 16'h0140, 0, 0, '0);
    send(CMD_WS_RPL, 0, 0, 16'h0141, 32'h1, 0, '0);
    send(CMD_RD_RPL, 1, 0, 16'h0140, 0, 0, blk(16'h0140));
    check("R8 stale ws", proc_hit, 0);

    // R5 reply hitting an existing line renames it only
    victim = 2; proc_vaddr = 16'h7100;
    send(CMD_RD_REQ, 1, 0, 16'h0100, 0, 0, '0);
    send(CMD_RD_RPL, 1, 0, 16'h0100, 0, 0, blk(16'h0B00));
    check("R5 vtag rename", proc_hit, 1);
    check("R5 keep data", proc_rdata, bw(16'h0100, 0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule